// File: doc/BRIEF.md
# Dual-Strobe Burst Address Sequencer

This block produces the word address for the front end of a synchronous burst memory. A new external address is captured on a rising clock edge when one of two active-low address strobes is recognized. One strobe belongs to the processor and one to a controller. The processor strobe outranks the controller strobe. It is also gated by the first chip enable, which is active low. In every capture cycle the three chip enables are sampled, and the result becomes the block's selected or deselected state. Between captures that state is held.

After a capture, the low two address bits act as a burst counter. An active-low advance input steps the counter once per clock while the block is selected. A static mode input picks the order of the burst. In linear order the counter counts upward and wraps modulo four. In interleaved order the start value is XORed with a step count. The upper sixteen bits stay fixed for the whole burst. The outputs are the current word address and the select status.

Top module: `dual_strobe_burst_seq`

## Requirements
- R1: After reset, `wordAddr` is 0 and `selected` is 0.
- R2: When `ctrlStrobeN` is low and the processor strobe is not recognized, `extAddr` is captured at the clock edge. It appears on `wordAddr` right after that edge.
- R3: When `procStrobeN` and `enOneN` are both low, `extAddr` is captured at the clock edge. Its bits [1:0] become the burst start, with the step count at zero.
- R4: When `procStrobeN` is low while `enOneN` is high, the processor strobe is ignored. If `ctrlStrobeN` is also high, `wordAddr` and `selected` keep their values.
- R5: When both strobes are low with `enOneN` low, the processor strobe is taken and `extAddr` is captured exactly once.
- R6: `selected` is set to (`enOneN`==0 && `enTwo`==1 && `enThreeN`==0) only in a capture cycle. In all other cycles, changes on the enables leave it unchanged.
- R7: With `interleaveSel`=0, each clock with `advanceN` low while selected makes `wordAddr[1:0]` equal to (start + n) mod 4, where n is the number of advances since the capture.
- R8: With `interleaveSel`=1, `wordAddr[1:0]` equals start XOR (n mod 4).
- R9: `wordAddr[17:2]` stays constant during a burst, and the low bits wrap back to the start after four advances.
- R10: While `selected` is 0, `advanceN` low has no effect on `wordAddr`.
- R11: With no recognized strobe and `advanceN` high, `wordAddr` and `selected` hold.
- R12: A capture in the same cycle as an advance takes precedence. The new address appears with the step count at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extAddr | input | 18 | External word address |
| procStrobeN | input | 1 | Processor address strobe, active low, higher priority |
| ctrlStrobeN | input | 1 | Controller address strobe, active low |
| enOneN | input | 1 | Chip enable one, active low; also gates the processor strobe |
| enTwo | input | 1 | Chip enable two, active high |
| enThreeN | input | 1 | Chip enable three, active low |
| advanceN | input | 1 | Burst advance, active low |
| interleaveSel | input | 1 | Burst order: 0 linear, 1 interleaved (static) |
| wordAddr | output | 18 | Current word address |
| selected | output | 1 | 1 when the last capture found all enables active |

## Verification
Every result of this block is due one clock after its stimulus. This covers a capture, an advance step and an update of the select state. The state is registered on the edge that samples the inputs, and the output address is formed from it by logic alone. The bench changes inputs on the falling edge and reads the outputs 1 ns after the next rising edge. At that point it compares them with a behavioural model that it updated from the same sampled inputs. Directed sequences check the hand-computed addresses for linear and interleaved bursts, for deselected advances, and for strobe priority. A long randomized run then compares the design with the model on every cycle.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  // Strobes passed from the control unit to the address datapath
  typedef struct packed {
    logic load;     // capture external address this edge
    logic advance;  // step the burst counter this edge
  } seqStrobes_t;

  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } burstOrder_e;
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        procStrobeN,
  input  logic        ctrlStrobeN,
  input  logic        enOneN,
  input  logic        enTwo,
  input  logic        enThreeN,
  input  logic        advanceN,
  output seqStrobes_t strobes,
  output logic        selected
);
  logic procHit;
  logic ctrlHit;
  logic loadNow;
  logic enablesOk;
  logic selReg;

  // Processor strobe is only seen while enable one is low; it outranks the controller
  assign procHit   = !procStrobeN && !enOneN;
  assign ctrlHit   = !ctrlStrobeN && !procHit;
  assign loadNow   = procHit || ctrlHit;
  assign enablesOk = !enOneN && enTwo && !enThreeN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg <= 1'b0;
    end else if (loadNow) begin
      selReg <= enablesOk;
    end
  end

  assign selected        = selReg;
  assign strobes.load    = loadNow;
  assign strobes.advance = !advanceN && selReg && !loadNow;

  // R4
  proc_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!procStrobeN && enOneN && ctrlStrobeN) |=> $stable(selected));

  // R6
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (procStrobeN && ctrlStrobeN) |=> $stable(selected));

  // R6
  sel_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlStrobeN && !enOneN && enTwo && !enThreeN) |=> selected);

  // R10
  no_adv_deselected_chk: assert property (@(posedge clk) disable iff (!rstN)
    !selected |-> !strobes.advance);
endmodule

// File: rtl/burst_seq_datapath.sv
module burst_seq_datapath
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] extAddr,
  input  logic              interleaveSel,
  input  seqStrobes_t       strobes,
  output logic [ADDR_W-1:0] wordAddr
);
  localparam int UPPER_W = ADDR_W - BURST_W;

  logic [UPPER_W-1:0] upperAddr;
  logic [BURST_W-1:0] startLow;
  logic [BURST_W-1:0] stepCnt;
  logic [BURST_W-1:0] linearLow;
  logic [BURST_W-1:0] interLow;
  logic [BURST_W-1:0] burstLow;
  burstOrder_e        order;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upperAddr <= '0;
      startLow  <= '0;
      stepCnt   <= '0;
    end else if (strobes.load) begin
      upperAddr <= extAddr[ADDR_W-1:BURST_W];
      startLow  <= extAddr[BURST_W-1:0];
      stepCnt   <= '0;
    end else if (strobes.advance) begin
      stepCnt   <= stepCnt + 1'b1;
    end
  end

  // Linear order: modular add of the step count to the start
  assign linearLow = startLow + stepCnt;

  // Interleaved order: per-bit toggle of the start by the step count
  for (genvar b = 0; b < BURST_W; b++) begin : g_inter
    assign interLow[b] = startLow[b] ^ stepCnt[b];
  end

  assign order = burstOrder_e'(interleaveSel);

  always_comb begin
    unique case (order)
      ORDER_INTERLEAVE: burstLow = interLow;
      default:          burstLow = linearLow;
    endcase
  end

  assign wordAddr = {upperAddr, burstLow};

  // R9
  upper_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> $stable(wordAddr[ADDR_W-1:BURST_W]));

  // R3
  load_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (startLow == $past(extAddr[BURST_W-1:0]) && stepCnt == '0));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.load && !strobes.advance) |=> $stable(stepCnt));

  // R7
  step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.load && strobes.advance) |=> stepCnt == BURST_W'($past(stepCnt) + 1));
endmodule

// File: rtl/dual_strobe_burst_seq.sv
module dual_strobe_burst_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] extAddr,
  input  logic              procStrobeN,
  input  logic              ctrlStrobeN,
  input  logic              enOneN,
  input  logic              enTwo,
  input  logic              enThreeN,
  input  logic              advanceN,
  input  logic              interleaveSel,
  output logic [ADDR_W-1:0] wordAddr,
  output logic              selected
);
  seqStrobes_t strobes;

  burst_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .procStrobeN(procStrobeN),
    .ctrlStrobeN(ctrlStrobeN),
    .enOneN     (enOneN),
    .enTwo      (enTwo),
    .enThreeN   (enThreeN),
    .advanceN   (advanceN),
    .strobes    (strobes),
    .selected   (selected)
  );

  burst_seq_datapath #(
    .ADDR_W (ADDR_W),
    .BURST_W(BURST_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .extAddr      (extAddr),
    .interleaveSel(interleaveSel),
    .strobes      (strobes),
    .wordAddr     (wordAddr)
  );
endmodule

// File: tb/sim_dual_strobe_burst_seq.sv
`timescale 1ns/1ps
module sim_dual_strobe_burst_seq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [17:0] extAddr = '0;
  logic        procStrobeN = 1'b1, ctrlStrobeN = 1'b1;
  logic        enOneN = 1'b1, enTwo = 1'b0, enThreeN = 1'b1;
  logic        advanceN = 1'b1, interleaveSel = 1'b0;
  logic [17:0] wordAddr;
  logic        selected;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  // behavioural reference state
  int refUpper = 0, refStart = 0, refStep = 0;
  bit refSel = 0;

  always #10 clk = ~clk;

  dual_strobe_burst_seq u0 (
    .clk(clk), .rstN(rstN), .extAddr(extAddr),
    .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN),
    .enOneN(enOneN), .enTwo(enTwo), .enThreeN(enThreeN),
    .advanceN(advanceN), .interleaveSel(interleaveSel),
    .wordAddr(wordAddr), .selected(selected)
  );

  function automatic logic [17:0] refAddr();
    int low;
    if (interleaveSel) low = refStart ^ refStep;
    else               low = (refStart + refStep) % 4;
    return 18'((refUpper * 4) + low);
  endfunction

  task automatic check(string req, logic [17:0] expA, logic expS);
    testsRun++;
    if (wordAddr !== expA || selected !== expS) begin
      testsFailed++;
      $display("FAIL %s: wordAddr=%h selected=%b expected wordAddr=%h selected=%b",
               req, wordAddr, selected, expA, expS);
    end
  endtask

  task automatic modelEdge();
    bit captured;
    bit procTaken;
    procTaken = (procStrobeN == 0) && (enOneN == 0);
    captured  = procTaken || (ctrlStrobeN == 0);
    if (captured) begin
      refUpper = int'(extAddr) / 4;
      refStart = int'(extAddr) % 4;
      refStep  = 0;
      refSel   = (enOneN == 0) && (enTwo == 1) && (enThreeN == 0);
    end else if (advanceN == 0 && refSel) begin
      refStep = (refStep + 1) % 4;
    end
  endtask

  // one clock: inputs set at the falling edge, outputs read 1 ns after the rising edge
  task automatic cyc(string req, bit pN, bit cN, bit e1N, bit e2, bit e3N, bit aN,
                     logic [17:0] a);
    @(negedge clk);
    procStrobeN = pN; ctrlStrobeN = cN; enOneN = e1N; enTwo = e2; enThreeN = e3N;
    advanceN = aN; extAddr = a;
    @(posedge clk);
    modelEdge();
    #1;
    check(req, refAddr(), refSel);
  endtask

  task automatic idle(string req);
    cyc(req, 1, 1, enOneN, enTwo, enThreeN, 1, extAddr);
  endtask

  task automatic adv(string req);
    cyc(req, 1, 1, enOneN, enTwo, enThreeN, 0, extAddr);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", 18'h0, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    idle("R1 after release");
    check("R1 idle", 18'h0, 1'b0);

    // R2: controller capture, linear order
    interleaveSel = 0;
    cyc("R2", 1, 0, 0, 1, 0, 1, 18'h2A5C1);
    check("R2 capture", 18'h2A5C1, 1'b1);
    adv("R7"); check("R7 step1", 18'h2A5C2, 1'b1);
    adv("R7"); check("R7 step2", 18'h2A5C3, 1'b1);
    adv("R7"); check("R9 wrap", 18'h2A5C0, 1'b1);
    adv("R7"); check("R9 back to start", 18'h2A5C1, 1'b1);
    idle("R11"); check("R11 hold", 18'h2A5C1, 1'b1);

    // R6: enables changing without a strobe leave select alone
    cyc("R6", 1, 1, 1, 0, 1, 1, 18'h00000);
    check("R6 sel held", 18'h2A5C1, 1'b1);

    // R3 and R8: processor capture, interleaved order
    interleaveSel = 1;
    cyc("R3", 0, 1, 0, 1, 0, 1, 18'h1F0F1);
    check("R3 capture", 18'h1F0F1, 1'b1);
    adv("R8"); check("R8 step1", 18'h1F0F0, 1'b1);
    adv("R8"); check("R8 step2", 18'h1F0F3, 1'b1);
    adv("R8"); check("R8 step3", 18'h1F0F2, 1'b1);
    adv("R8"); check("R9 interleave wrap", 18'h1F0F1, 1'b1);

    // R4: processor strobe with enable one high is ignored
    cyc("R4", 0, 1, 1, 1, 0, 1, 18'h3FFFF);
    check("R4 ignored", 18'h1F0F1, 1'b1);

    // R5: both strobes, single capture
    cyc("R5", 0, 0, 0, 1, 0, 1, 18'h00012);
    check("R5 both strobes", 18'h00012, 1'b1);

    // R6 and R10: capture with enable two inactive, then advances do nothing
    interleaveSel = 0;
    cyc("R6", 1, 0, 0, 0, 0, 1, 18'h11113);
    check("R6 deselect", 18'h11113, 1'b0);
    adv("R10"); check("R10 no step", 18'h11113, 1'b0);
    adv("R10"); check("R10 no step 2", 18'h11113, 1'b0);

    // R12: capture and advance together
    cyc("R12", 1, 0, 0, 1, 0, 0, 18'h20002);
    check("R12 load wins", 18'h20002, 1'b1);
    adv("R12"); check("R12 next step", 18'h20003, 1'b1);

    // randomized comparison against the model
    for (int i = 0; i < 400; i++) begin
      if (i % 50 == 0) interleaveSel = $urandom_range(0, 1);
      cyc("R7/R8 random", ($urandom_range(0, 7) != 0), ($urandom_range(0, 5) != 0),
          ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) != 0),
          ($urandom_range(0, 3) == 0), ($urandom_range(0, 2) == 0),
          18'($urandom));
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: run did not complete, actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule